// File: doc/BRIEF.md
# Asymmetric Integrating Lock Detector

This block decides whether a phase-locked loop has settled. Its input is a quiet indication from a phase-frequency detector: the NOR of the detector's up and down activity, high whenever no phase correction is being applied. While the loop tracks, the indication stays high except for short low pulses whose width equals the residual phase error. The block feeds this level into a saturating digital integrator. The integrator climbs by a large step on each clock cycle that the indication is high and falls by a small step on each cycle that it is low. The two steps are in a ratio of about eleven to one.

A comparator with hysteresis watches the integrator value and drives an active-high lock flag. The flag rises only once the value reaches an upper threshold. It drops only once the value falls below a lower threshold. Brief error pulses during tracking, acquisition or lock loss therefore cannot toggle the flag. The two step sizes, the two thresholds and the integrator width are parameters. They are scaled to the oscillator centre frequency: a slower loop needs a deeper integrator.

Top module: `lockdet_top`

## Requirements
- R1: A synchronous active-high reset clears the integrator to zero, and the lock flag is low on the first edge after reset.
- R2: On each clock edge where the quiet input is high, the integrator rises by CHARGE_STEP (default 11).
- R3: On each clock edge where the quiet input is low, the integrator falls by DRAIN_STEP (default 1).
- R4: The integrator saturates at 2^ACC_W-1 (default 255) and never wraps to a small value.
- R5: The integrator saturates at zero and never wraps to a large value.
- R6: While unlocked, the lock flag goes high on the clock edge where the integrator value registered at the previous edge is at least RISE_TH (default 200).
- R7: While locked, the lock flag goes low on the clock edge where the registered integrator value is below FALL_TH (default 100).
- R8: While the integrator is at or above FALL_TH but below RISE_TH, the lock flag keeps its previous value.
- R9: Short error pulses (a few low cycles between long high stretches) do not clear a lock flag that is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pfd_quiet | input | 1 | High when the phase detector shows no up or down activity |
| lock_o | output | 1 | Active-high lock indication |

## Verification
The integrator is driven with long high stretches from zero, which time the rise threshold to the exact cycle. Long low stretches from saturation time the fall threshold and show whether the top clamp holds. A long low run from a high value separates clamping at zero from wrap-around. Repeated rising segments from between the thresholds show that the flag holds its old state in the hysteresis band. A tracking pattern of short error pulses shows that glitches do not drop the flag, and a pattern that is mostly low shows that the flag is lost.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    typedef enum logic {
        LK_UNLOCKED = 1'b0,
        LK_LOCKED   = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic charge;
        logic drain;
    } step_cmd_t;

    function automatic step_cmd_t decode_quiet(input logic quiet);
        step_cmd_t cmd;
        cmd.charge = quiet;
        cmd.drain  = ~quiet;
        return cmd;
    endfunction

    function automatic int unsigned sat_add(input int unsigned val,
                                            input int unsigned step,
                                            input int unsigned ceil);
        int unsigned room;
        room = ceil - val;
        return (step > room) ? ceil : val + step;
    endfunction

    function automatic int unsigned sat_sub(input int unsigned val,
                                            input int unsigned step);
        return (step > val) ? 0 : val - step;
    endfunction

endpackage

// File: rtl/lockdet_integrator.sv
module lockdet_integrator
    import lockdet_pkg::*;
#(
    parameter int unsigned ACC_W       = 8,
    parameter int unsigned CHARGE_STEP = 11,
    parameter int unsigned DRAIN_STEP  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  step_cmd_t        cmd,
    output logic [ACC_W-1:0] level
);
    localparam int unsigned ACC_MAX = (1 << ACC_W) - 1;

    logic [ACC_W-1:0] level_nxt;

    always_comb begin
        level_nxt = level;
        if (cmd.charge) begin
            level_nxt = ACC_W'(sat_add(32'(level), CHARGE_STEP, ACC_MAX));
        end else if (cmd.drain) begin
            level_nxt = ACC_W'(sat_sub(32'(level), DRAIN_STEP));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            level <= level_nxt;
        end
    end

    // R1
    a_r1_level_cleared: assert property (@(posedge clk)
        rst |=> (level == '0));
    // R4: charging never lowers the value
    a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
        cmd.charge |=> (level >= $past(level)));
    // R5: draining never raises the value
    a_r5_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
        cmd.drain |=> (level <= $past(level)));
    // R2: charging from zero gives a non-zero value
    a_r2_charge_moves: assert property (@(posedge clk) disable iff (rst)
        (cmd.charge && level == '0) |=> (level != '0));

endmodule

// File: rtl/lockdet_schmitt.sv
module lockdet_schmitt
    import lockdet_pkg::*;
#(
    parameter int unsigned ACC_W   = 8,
    parameter int unsigned RISE_TH = 200,
    parameter int unsigned FALL_TH = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] level,
    output logic             locked
);
    localparam logic [ACC_W-1:0] RISE_V = ACC_W'(RISE_TH);
    localparam logic [ACC_W-1:0] FALL_V = ACC_W'(FALL_TH);

    lock_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            LK_UNLOCKED: if (level >= RISE_V) state_nxt = LK_LOCKED;
            LK_LOCKED:   if (level <  FALL_V) state_nxt = LK_UNLOCKED;
            default:     state_nxt = LK_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_UNLOCKED;
        end else begin
            state <= state_nxt;
        end
    end

    assign locked = (state == LK_LOCKED);

    // R1
    a_r1_flag_low: assert property (@(posedge clk)
        rst |=> !locked);
    // R6
    a_r6_set: assert property (@(posedge clk) disable iff (rst)
        (!locked && level >= RISE_V) |=> locked);
    // R7
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (level < FALL_V) |=> !locked);
    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (level >= FALL_V && level < RISE_V) |=> (locked == $past(locked)));

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int unsigned ACC_W       = 8,
    parameter int unsigned CHARGE_STEP = 11,
    parameter int unsigned DRAIN_STEP  = 1,
    parameter int unsigned RISE_TH     = 200,
    parameter int unsigned FALL_TH     = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic pfd_quiet,
    output logic lock_o
);
    step_cmd_t        cmd;
    logic [ACC_W-1:0] level;

    assign cmd = decode_quiet(pfd_quiet);

    lockdet_integrator #(
        .ACC_W      (ACC_W),
        .CHARGE_STEP(CHARGE_STEP),
        .DRAIN_STEP (DRAIN_STEP)
    ) u_integ (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .level(level)
    );

    lockdet_schmitt #(
        .ACC_W  (ACC_W),
        .RISE_TH(RISE_TH),
        .FALL_TH(FALL_TH)
    ) u_schmitt (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .locked(lock_o)
    );

    // R9: a single error cycle never drops the flag when it was high twice running
    a_r9_glitch_hold: assert property (@(posedge clk) disable iff (rst)
        (lock_o && $past(lock_o) && pfd_quiet && !$past(pfd_quiet) && $past(pfd_quiet, 2)
         && level >= ACC_W'(FALL_TH + 2 * DRAIN_STEP)) |=> lock_o);

endmodule

// File: tb/lockdet_top_test.sv
module lockdet_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pfd_quiet = 1'b0;
    logic lock_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lockdet_top uut (
        .clk      (clk),
        .rst      (rst),
        .pfd_quiet(pfd_quiet),
        .lock_o   (lock_o)
    );

    typedef struct packed {
        logic        lvl;
        logic [15:0] cycles;
        logic        exp_lock;
        logic [7:0]  req;
    } vec_t;

    // integrator value after each step in comments (charge 11, drain 1, max 255)
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'd19,  1'b0, 8'd6},  // 209, edge saw 198: R6 not yet
        '{1'b1, 16'd1,   1'b1, 8'd6},  // 220, saw 209
        '{1'b1, 16'd10,  1'b1, 8'd4},  // clamps at 255
        '{1'b0, 16'd155, 1'b1, 8'd3},  // 100
        '{1'b0, 16'd1,   1'b1, 8'd7},  // 99, saw 100
        '{1'b0, 16'd1,   1'b0, 8'd7},  // 98, saw 99: R4 clamp confirmed
        '{1'b1, 16'd9,   1'b0, 8'd8},  // 197
        '{1'b1, 16'd1,   1'b0, 8'd8},  // 208, saw 197
        '{1'b1, 16'd1,   1'b1, 8'd6},  // 219, saw 208
        '{1'b0, 16'd5,   1'b1, 8'd9},  // 214
        '{1'b1, 16'd1,   1'b1, 8'd2},  // 225
        '{1'b0, 16'd250, 1'b0, 8'd5},  // clamps at 0
        '{1'b1, 16'd18,  1'b0, 8'd5},  // 198
        '{1'b1, 16'd1,   1'b0, 8'd5},  // 209, saw 198
        '{1'b1, 16'd1,   1'b1, 8'd5}   // 220, saw 209
    };

    task automatic check(input logic exp, input int req, input string what);
        checks++;
        if (lock_o !== exp) begin
            fails++;
            $display("FAIL R%0d %s: lock_o=%b expected=%b", req, what, lock_o, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int n);
        pfd_quiet = lvl;
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        pfd_quiet = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, 1, "R1 flag low in reset");
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].lvl, int'(VECS[v].cycles));
            check(VECS[v].exp_lock, int'(VECS[v].req), $sformatf("vector %0d", v));
        end

        // R1: reset while locked clears flag and integrator
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1'b0, 1, "R1 flag cleared by reset while locked");
        rst = 1'b0;
        drive(1'b1, 19);
        check(1'b0, 1, "R1 integrator restarted from zero");
        drive(1'b1, 1);
        check(1'b1, 2, "R2 relock after 20 charge cycles");

        // R9: tracking pattern with short error pulses keeps lock
        for (int k = 0; k < 20; k++) begin
            drive(1'b0, 2);
            drive(1'b1, 8);
        end
        check(1'b1, 9, "R9 short pulses keep lock");

        // R3: loss pattern, mostly error; after 10 rounds still above 100
        drive(1'b1, 10);
        for (int k = 0; k < 10; k++) begin
            drive(1'b0, 20);
            drive(1'b1, 1);
        end
        check(1'b1, 3, "R3 slow drain keeps lock for 10 rounds");
        for (int k = 0; k < 20; k++) begin
            drive(1'b0, 20);
            drive(1'b1, 1);
        end
        check(1'b0, 7, "R7 lock lost under wide error pulses");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule